// File: doc/BRIEF.md
# Compare and Loop Branch Unit

This block makes the branch decision for the conditional relative branches of an 8-bit microcontroller core. It handles four kinds of branch: compare two bytes and branch when they differ, decrement a byte and branch while the result is nonzero, branch when a bit is set, and branch when a bit is set while also clearing that bit. The core's operand stage supplies the operand bytes or the tested bit, the carry flag, the signed 8-bit displacement, the address of the instruction and its length in bytes. The block returns the next program counter, the new carry, the byte and bit to write back, and a taken flag.

The next program counter is always formed from the address of the following instruction. The displacement is sign-extended to the counter width and added when the branch is taken. All counter arithmetic wraps modulo 2^PC_W. The outputs are registered: an operation presented with `in_valid` high appears on the outputs at the next clock edge, and the outputs hold their values while no operation is presented.

Top module: `cmp_loop_branch`

## Requirements
- R1: A branch that is not taken gives `out_next_pc` = `in_pc` + `in_len`, modulo 65536.
- R2: A taken branch gives `out_next_pc` = `in_pc` + `in_len` + the sign-extended `in_disp`, modulo 65536, so displacements 80h..FFh move backwards.
- R3: With `in_kind` = 0 (compare), the branch is taken exactly when `in_dest` differs from `in_src`, and `out_wb_byte` equals the unmodified `in_dest`.
- R4: With `in_kind` = 0, `out_carry` is 1 when `in_dest` is less than `in_src` as unsigned values, and 0 otherwise.
- R5: With `in_kind` = 1 (decrement), `out_wb_byte` = `in_dest` - 1, with 00h wrapping to FFh, and the branch is taken exactly when that result is nonzero.
- R6: With `in_kind` = 1, 2 or 3, `out_carry` equals `in_carry`.
- R7: With `in_kind` = 2 (bit test) or 3 (bit test and clear), the branch is taken exactly when `in_bit` is 1. Kind 3 gives `out_wb_bit` = 0 in every case, so a set bit is cleared and a clear bit stays clear. All other kinds give `out_wb_bit` = `in_bit`.
- R8: `out_valid` equals `in_valid` one clock edge earlier. The data outputs load only at an edge where `in_valid` is 1, and keep their values otherwise.
- R9: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_kind | input | 2 | 0 compare, 1 decrement, 2 bit test, 3 bit test and clear |
| in_dest | input | 8 | First compare operand, or the byte to decrement |
| in_src | input | 8 | Second compare operand |
| in_bit | input | 1 | Tested bit value |
| in_carry | input | 1 | Current carry flag |
| in_disp | input | 8 | Signed relative displacement |
| in_pc | input | 16 | Address of the branch instruction |
| in_len | input | 2 | Instruction length in bytes |
| out_valid | output | 1 | Outputs hold a new result |
| out_next_pc | output | 16 | Address of the next instruction to run |
| out_carry | output | 1 | Updated carry flag |
| out_wb_byte | output | 8 | Byte to write back |
| out_wb_bit | output | 1 | Bit to write back |
| out_taken | output | 1 | Branch taken |

## Verification
Compare is tried with equal operands, destination below source and destination above source. These patterns separate the inequality test from the unsigned less-than carry and show that a taken branch can still clear the carry. Decrement is tried with 01h, 70h and 00h, which separate the not-taken result of exactly zero, an ordinary taken loop and the 00h-to-FFh wrap. Both bit kinds are tried with the bit set and clear, to show that clearing happens only on the clear kind. Forward, backward and zero displacements are placed so that they cross the 16-bit boundary in both directions.

// File: rtl/cmp_loop_branch_pkg.sv
`timescale 1ns/1ps
package cmp_loop_branch_pkg;

   typedef enum logic [1:0] {
      BRK_CMP    = 2'd0,
      BRK_DEC    = 2'd1,
      BRK_BIT    = 2'd2,
      BRK_BITCLR = 2'd3
   } brk_kind_e;

   // one decided branch, as stored in the output register
   typedef struct packed {
      logic [15:0] next_pc;
      logic        carry;
      logic [7:0]  wb_byte;
      logic        wb_bit;
      logic        taken;
   } brk_result_t;

endpackage

// File: rtl/clb_target.sv
`timescale 1ns/1ps
// Fall-through and relative target address generation.
module clb_target #(
   parameter int PC_W   = 16,
   parameter int DISP_W = 8,
   parameter int LEN_W  = 2
) (
   input  logic [PC_W-1:0]   pc,
   input  logic [LEN_W-1:0]  len,
   input  logic [DISP_W-1:0] disp,
   output logic [PC_W-1:0]   fall_pc,
   output logic [PC_W-1:0]   jump_pc
);
   localparam int LEN_PAD = PC_W - LEN_W;

   logic [PC_W-1:0] disp_ext;

   if (PC_W < DISP_W || PC_W < LEN_W) begin : g_bad_width
      $error("clb_target: PC_W must cover DISP_W and LEN_W");
   end

   // sign extension: a displacement as wide as the counter needs none
   if (PC_W == DISP_W) begin : g_disp_full
      assign disp_ext = disp;
   end else begin : g_disp_sext
      assign disp_ext = {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp};
   end

   if (LEN_PAD == 0) begin : g_len_full
      assign fall_pc = pc + len;
   end else begin : g_len_pad
      assign fall_pc = pc + {{LEN_PAD{1'b0}}, len};
   end

   assign jump_pc = fall_pc + disp_ext;
endmodule

// File: rtl/clb_compare.sv
`timescale 1ns/1ps
// Byte comparison: inequality and unsigned less-than.
module clb_compare #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   output logic              differ,
   output logic              below
);
   if (DATA_W < 1) begin : g_bad_width
      $error("clb_compare: DATA_W must be positive");
   end

   logic [DATA_W:0] diff;

   // the borrow out of lhs - rhs marks lhs < rhs
   assign diff   = {1'b0, lhs} - {1'b0, rhs};
   assign below  = diff[DATA_W];
   assign differ = |diff[DATA_W-1:0];
endmodule

// File: rtl/clb_countdown.sv
`timescale 1ns/1ps
// Wrapping decrement with nonzero detect.
module clb_countdown #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] value,
   output logic [DATA_W-1:0] next_value,
   output logic              nonzero
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   if (DATA_W < 1) begin : g_bad_width
      $error("clb_countdown: DATA_W must be positive");
   end

   assign next_value = value - ONE;
   // the result is zero only when the input was exactly one
   assign nonzero    = (value != ONE);
endmodule

// File: rtl/clb_bittest.sv
`timescale 1ns/1ps
// Bit test with optional clear of a set bit.
module clb_bittest (
   input  logic bit_in,
   input  logic clear_en,
   output logic hit,
   output logic bit_out
);
   assign hit     = bit_in;
   assign bit_out = bit_in & ~clear_en;
endmodule

// File: rtl/cmp_loop_branch.sv
`timescale 1ns/1ps
module cmp_loop_branch
   import cmp_loop_branch_pkg::*;
#(
   parameter int PC_W    = 16,
   parameter int DATA_W  = 8,
   parameter int DISP_W  = 8,
   parameter int LEN_W   = 2,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        in_kind,
   input  logic [DATA_W-1:0] in_dest,
   input  logic [DATA_W-1:0] in_src,
   input  logic              in_bit,
   input  logic              in_carry,
   input  logic [DISP_W-1:0] in_disp,
   input  logic [PC_W-1:0]   in_pc,
   input  logic [LEN_W-1:0]  in_len,
   output logic              out_valid,
   output logic [PC_W-1:0]   out_next_pc,
   output logic              out_carry,
   output logic [DATA_W-1:0] out_wb_byte,
   output logic              out_wb_bit,
   output logic              out_taken
);
   localparam int RES_W = PC_W + DATA_W + 3;

   if (PC_W < DISP_W) begin : g_bad_pc
      $error("cmp_loop_branch: PC_W narrower than DISP_W");
   end
   if (LEN_W < 2) begin : g_bad_len
      $error("cmp_loop_branch: LEN_W must hold a length of 3");
   end

   brk_kind_e kind;
   assign kind = brk_kind_e'(in_kind);

   logic [PC_W-1:0]   fall_pc, jump_pc;
   logic              cmp_ne, cmp_lt;
   logic [DATA_W-1:0] dec_val;
   logic              dec_nz;
   logic              bit_hit, bit_new;

   clb_target #(.PC_W(PC_W), .DISP_W(DISP_W), .LEN_W(LEN_W)) u_target (
      .pc      (in_pc),
      .len     (in_len),
      .disp    (in_disp),
      .fall_pc (fall_pc),
      .jump_pc (jump_pc)
   );

   clb_compare #(.DATA_W(DATA_W)) u_compare (
      .lhs    (in_dest),
      .rhs    (in_src),
      .differ (cmp_ne),
      .below  (cmp_lt)
   );

   clb_countdown #(.DATA_W(DATA_W)) u_countdown (
      .value      (in_dest),
      .next_value (dec_val),
      .nonzero    (dec_nz)
   );

   clb_bittest u_bittest (
      .bit_in   (in_bit),
      .clear_en (kind == BRK_BITCLR),
      .hit      (bit_hit),
      .bit_out  (bit_new)
   );

   // decision for the presented operation
   logic              d_taken;
   logic              d_carry;
   logic [DATA_W-1:0] d_byte;
   logic              d_bit;
   logic [PC_W-1:0]   d_pc;

   always_comb begin
      d_taken = 1'b0;
      d_carry = in_carry;
      d_byte  = in_dest;
      d_bit   = in_bit;
      unique case (kind)
         BRK_CMP: begin
            d_taken = cmp_ne;
            d_carry = cmp_lt;
         end
         BRK_DEC: begin
            d_taken = dec_nz;
            d_byte  = dec_val;
         end
         BRK_BIT: begin
            d_taken = bit_hit;
         end
         BRK_BITCLR: begin
            d_taken = bit_hit;
            d_bit   = bit_new;
         end
         default: ;
      endcase
      d_pc = d_taken ? jump_pc : fall_pc;
   end

   logic [RES_W-1:0] d_res, q_res;
   assign d_res = {d_pc, d_carry, d_byte, d_bit, d_taken};

   if (REG_OUT) begin : g_reg
      logic q_valid;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q_valid <= 1'b0;
            q_res   <= '0;
         end else begin
            q_valid <= in_valid;
            if (in_valid) q_res <= d_res;
         end
      end

      assign out_valid = q_valid;

      assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      assert_idle_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> ($stable(out_next_pc) && $stable(out_wb_byte) && $stable(out_taken)));
      assert_fallthrough_R1: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> (out_taken || out_next_pc == $past(in_pc + PC_W'(in_len))));
      assert_cmp_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_kind == 2'd0) |=> (out_carry == ($past(in_dest) < $past(in_src))));
      assert_carry_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_kind != 2'd0) |=> (out_carry == $past(in_carry)));
      assert_cmp_keeps_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_kind == 2'd0) |=> (out_wb_byte == $past(in_dest)));
      assert_bitclr_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_kind == 2'd3) |=> !out_wb_bit);
   end else begin : g_comb
      assign out_valid = in_valid;
      assign q_res     = d_res;
   end

   assign {out_next_pc, out_carry, out_wb_byte, out_wb_bit, out_taken} = q_res;
endmodule

// File: tb/cmp_loop_branch_test.sv
`timescale 1ns/1ps
module cmp_loop_branch_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [1:0]  in_kind;
   logic [7:0]  in_dest, in_src, in_disp;
   logic        in_bit, in_carry;
   logic [15:0] in_pc;
   logic [1:0]  in_len;
   logic        out_valid;
   logic [15:0] out_next_pc;
   logic        out_carry;
   logic [7:0]  out_wb_byte;
   logic        out_wb_bit;
   logic        out_taken;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   cmp_loop_branch uut (
      .clk, .rst_n, .in_valid, .in_kind, .in_dest, .in_src, .in_bit,
      .in_carry, .in_disp, .in_pc, .in_len, .out_valid, .out_next_pc,
      .out_carry, .out_wb_byte, .out_wb_bit, .out_taken
   );

   typedef struct packed {
      logic [1:0]  kind;
      logic [7:0]  dest;
      logic [7:0]  src;
      logic        bitv;
      logic        carry;
      logic [7:0]  disp;
      logic [15:0] pc;
      logic [1:0]  len;
      logic [15:0] e_pc;
      logic        e_carry;
      logic [7:0]  e_byte;
      logic        e_bit;
      logic        e_taken;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      // compare, dest < src: taken, carry set (R3 R4)
      '{2'd0, 8'h56, 8'h60, 1'b0, 1'b0, 8'h10, 16'h0100, 2'd3, 16'h0113, 1'b1, 8'h56, 1'b0, 1'b1},
      // compare, equal: not taken, carry cleared
      '{2'd0, 8'h60, 8'h60, 1'b0, 1'b1, 8'h10, 16'h0100, 2'd3, 16'h0103, 1'b0, 8'h60, 1'b0, 1'b0},
      // compare, dest > src, backward jump, carry cleared
      '{2'd0, 8'h80, 8'h20, 1'b1, 1'b1, 8'hF0, 16'h0100, 2'd3, 16'h00F3, 1'b0, 8'h80, 1'b1, 1'b1},
      // decrement 01h -> 00h: not taken, carry kept (R5 R6)
      '{2'd1, 8'h01, 8'h00, 1'b0, 1'b1, 8'h20, 16'h0200, 2'd2, 16'h0202, 1'b1, 8'h00, 1'b0, 1'b0},
      // decrement 70h -> 6Fh: taken
      '{2'd1, 8'h70, 8'h00, 1'b0, 1'b0, 8'h20, 16'h0202, 2'd3, 16'h0225, 1'b0, 8'h6F, 1'b0, 1'b1},
      // decrement 00h wraps to FFh: taken, jumps back to itself
      '{2'd1, 8'h00, 8'h00, 1'b0, 1'b0, 8'hFE, 16'h0300, 2'd2, 16'h0300, 1'b0, 8'hFF, 1'b0, 1'b1},
      // bit test set: taken, bit kept (R7)
      '{2'd2, 8'hAA, 8'h00, 1'b1, 1'b1, 8'h05, 16'h1000, 2'd3, 16'h1008, 1'b1, 8'hAA, 1'b1, 1'b1},
      // bit test clear: not taken
      '{2'd2, 8'hAA, 8'h00, 1'b0, 1'b1, 8'h05, 16'h1000, 2'd3, 16'h1003, 1'b1, 8'hAA, 1'b0, 1'b0},
      // bit test and clear, set: taken, bit cleared, largest forward step
      '{2'd3, 8'h11, 8'h00, 1'b1, 1'b0, 8'h7F, 16'h2000, 2'd3, 16'h2082, 1'b0, 8'h11, 1'b0, 1'b1},
      // bit test and clear, already clear: not taken, stays clear
      '{2'd3, 8'h11, 8'h00, 1'b0, 1'b0, 8'h7F, 16'h2000, 2'd3, 16'h2003, 1'b0, 8'h11, 1'b0, 1'b0},
      // compare across the top of the address space (R2 wrap)
      '{2'd0, 8'h01, 8'h00, 1'b0, 1'b0, 8'h02, 16'hFFFE, 2'd3, 16'h0003, 1'b0, 8'h01, 1'b0, 1'b1},
      // decrement not taken, fall-through wraps (R1 wrap)
      '{2'd1, 8'h01, 8'h00, 1'b0, 1'b0, 8'h40, 16'hFFFF, 2'd2, 16'h0001, 1'b0, 8'h00, 1'b0, 1'b0},
      // decrement taken, largest backward step wraps below zero
      '{2'd1, 8'h05, 8'h00, 1'b0, 1'b1, 8'h80, 16'h0000, 2'd2, 16'hFF82, 1'b1, 8'h04, 1'b0, 1'b1},
      // compare 00h against FFh, zero displacement
      '{2'd0, 8'h00, 8'hFF, 1'b0, 1'b0, 8'h00, 16'h0010, 2'd3, 16'h0013, 1'b1, 8'h00, 1'b0, 1'b1}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      in_kind  = v.kind;
      in_dest  = v.dest;
      in_src   = v.src;
      in_bit   = v.bitv;
      in_carry = v.carry;
      in_disp  = v.disp;
      in_pc    = v.pc;
      in_len   = v.len;
   endtask

   initial begin : watchdog
      #200000;
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      rst_n    = 1'b0;
      in_valid = 1'b1;
      drive(VEC[0]);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9: reset clears every output even with an operation presented
      chk("R9 valid", 32'(out_valid), 32'd0);
      chk("R9 next_pc", 32'(out_next_pc), 32'd0);
      chk("R9 flags", 32'({out_carry, out_wb_bit, out_taken}), 32'd0);
      chk("R9 byte", 32'(out_wb_byte), 32'd0);
      rst_n    = 1'b1;
      in_valid = 1'b0;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i]);
         in_valid = 1'b1;
         @(negedge clk);
         chk("R8 valid", 32'(out_valid), 32'd1);
         chk("R1 R2 next_pc", 32'(out_next_pc), 32'(VEC[i].e_pc));
         chk("R4 R6 carry", 32'(out_carry), 32'(VEC[i].e_carry));
         chk("R3 R5 wb_byte", 32'(out_wb_byte), 32'(VEC[i].e_byte));
         chk("R7 wb_bit", 32'(out_wb_bit), 32'(VEC[i].e_bit));
         chk("R3 R5 R7 taken", 32'(out_taken), 32'(VEC[i].e_taken));
      end

      // R8: idle cycles leave the last result in place despite new inputs
      in_valid = 1'b0;
      drive(VEC[1]);
      @(negedge clk);
      chk("R8 idle valid", 32'(out_valid), 32'd0);
      chk("R8 hold next_pc", 32'(out_next_pc), 32'h0013);
      chk("R8 hold carry", 32'(out_carry), 32'd1);
      chk("R8 hold taken", 32'(out_taken), 32'd1);
      @(negedge clk);
      chk("R8 hold byte", 32'(out_wb_byte), 32'h00);

      // R5: loop counter chained through write-back, 03h -> 02h -> 01h -> 00h
      in_valid = 1'b1;
      in_kind  = 2'd1;
      in_dest  = 8'h03;
      in_pc    = 16'h0400;
      in_len   = 2'd2;
      in_disp  = 8'hFE;
      for (int n = 2; n >= 0; n--) begin
         @(negedge clk);
         chk("R5 loop byte", 32'(out_wb_byte), 32'(n));
         chk("R5 loop taken", 32'(out_taken), 32'(n != 0));
         chk("R1 R2 loop pc", 32'(out_next_pc), (n != 0) ? 32'h0400 : 32'h0402);
         in_dest = out_wb_byte;
      end
      in_valid = 1'b0;
      @(negedge clk);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule